// File: doc/BRIEF.md
# Address-Wakeup Serial Receiver with Error Flags

This block receives asynchronous serial characters on one line and turns them into parallel data words. It samples the line on a 16x oversampling tick supplied from outside. Each bit is decided by a three-sample majority vote near the middle of the bit. A character has one low start bit, then data bits sent least significant first, then one stop bit. There are eight data bits normally and nine when the wide-character mode is on. The last data bit is the most significant one, and it marks an address character.

Software talks to the block through a small register port. A status register holds four flags: receive-full, overrun, noise and framing error. It also shows the wakeup bit and the mode bit. A data register holds the last accepted character. A control register sets the wakeup bit and the mode. A status read followed by a data read clears the flags that the status read saw set.

Software can set the wakeup bit to skip a message that is not addressed to it. While the bit is set, received characters raise no flags and do not update the data register. The first character whose most significant bit is high clears the wakeup bit before its stop bit. That same character is then received in the normal way.

Top module: `awu_uart_rx`

## Requirements
- R1: Characters are assembled least significant bit first. In narrow mode (control bit 1 = 0) eight data bits are taken and data register bit 8 reads 0. In wide mode (control bit 1 = 1) nine bits are taken. An accepted character sets receive-full (status bit 0).
- R2: Each bit is the majority of three samples. A single deviating sample in the start, data or stop bit does not change the decoded value. It does set noise (status bit 2), which is only ever set together with receive-full.
- R3: A low pulse that has ended by the middle of the start bit is rejected. It produces no character and no flag.
- R4: A stop bit decided low sets framing error (status bit 3) in the same update as receive-full. The character is still stored.
- R5: A character that completes while receive-full or framing error is pending sets overrun (status bit 1). It is discarded, and the data register keeps its old value.
- R6: When a character would cause both a framing error and an overrun, only overrun is reported.
- R7: A status read (address 0) arms the clear. A later data read (address 1) clears exactly the flags that were set at that status read. A data read with no status read before it clears nothing, and a flag raised after the status read survives the data read.
- R8: Writing control bit 0 = 1 (address 2) sets the wakeup bit, shown as status bit 4. While it is set, characters change no flag and not the data register.
- R9: A character whose most significant data bit is 1 clears the wakeup bit while the character is still being received. The data bit used is bit 7 in narrow mode and bit 8 in wide mode. The character is then accepted normally.
- R10: After reset all flags, the wakeup bit, the mode bit and the data register read 0. Status bit 5 reflects the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | 0 status, 1 data, 2 control |
| wdata_i | input | 2 | Control write: bit 0 wakeup, bit 1 wide mode |
| rdata_o | output | 9 | Read data for the addressed register |

## Verification
Some rules are checked by assertions on every cycle. These are that noise and framing flags never stand without receive-full, and that the data register holds still while a character is pending or a framing error blocks transfers. They also check that overrun never also raises framing, that characters change nothing while the wakeup bit is set, and that a high most significant bit leaves the wakeup bit clear. Flags may fall only after an armed data read. The bench scenarios are what show bit order, majority decisions against injected glitches, start-bit rejection, and the stored values after overrun. They also show the message-skipping sequence across several characters in both widths.

// File: rtl/awu_uart_rx_pkg.sv
package awu_uart_rx_pkg;
   typedef enum logic [1:0] {
      RX_HUNT  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_phase_e;

   localparam logic [1:0] REG_STAT = 2'd0;
   localparam logic [1:0] REG_DATA = 2'd1;
   localparam logic [1:0] REG_CTRL = 2'd2;

   localparam int FLG_FULL  = 0;
   localparam int FLG_OVR   = 1;
   localparam int FLG_NOISE = 2;
   localparam int FLG_FRAME = 3;
   localparam int NUM_FLAGS = 4;
   localparam int STAT_W    = 6;
endpackage

// File: rtl/awu_rx_sampler.sv
module awu_rx_sampler
   import awu_uart_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              line_i,
   input  logic              wide_i,
   output logic              done_o,
   output logic [DATA_W:0]   data_o,
   output logic              noise_o,
   output logic              stop_bad_o,
   output logic              mark_o
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OVS / 2);
   localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OVS / 2 + 1);
   localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(DATA_W);

   if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 8");
   end
   if (DATA_W < 5) begin : g_bad_width
      $error("DATA_W must be at least 5");
   end

   rx_phase_e          phase_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic [DATA_W:0]    shift_q;
   logic [1:0]         smp_q;
   logic               noise_acc_q;
   logic               vote, split, decide, last_bit;

   assign vote     = (smp_q[0] & smp_q[1]) | (smp_q[0] & line_i) | (smp_q[1] & line_i);
   assign split    = (smp_q[0] != smp_q[1]) || (smp_q[1] != line_i);
   assign decide   = tick_i && (phase_q != RX_HUNT) && (cnt_q == SMP_C);
   assign last_bit = (idx_q == (wide_i ? LAST_WIDE : LAST_NARROW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= RX_HUNT;
         cnt_q       <= '0;
         idx_q       <= '0;
         shift_q     <= '0;
         smp_q       <= '0;
         noise_acc_q <= 1'b0;
         done_o      <= 1'b0;
         data_o      <= '0;
         noise_o     <= 1'b0;
         stop_bad_o  <= 1'b0;
         mark_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         mark_o <= 1'b0;
         if (tick_i) begin
            if (phase_q == RX_HUNT) begin
               if (!line_i) begin
                  phase_q     <= RX_START;
                  cnt_q       <= CNT_W'(1);
                  idx_q       <= '0;
                  shift_q     <= '0;
                  noise_acc_q <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == SMP_A) smp_q[0] <= line_i;
               if (cnt_q == SMP_B) smp_q[1] <= line_i;
               if (decide) begin
                  noise_acc_q <= noise_acc_q | split;
                  case (phase_q)
                     RX_START: if (vote) phase_q <= RX_HUNT;
                               else      phase_q <= RX_BITS;
                     RX_BITS: begin
                        shift_q[idx_q] <= vote;
                        idx_q          <= idx_q + 1'b1;
                        if (last_bit) begin
                           phase_q <= RX_STOP;
                           mark_o  <= vote;
                        end
                     end
                     RX_STOP: begin
                        phase_q    <= RX_HUNT;
                        done_o     <= 1'b1;
                        data_o     <= shift_q;
                        noise_o    <= noise_acc_q | split;
                        stop_bad_o <= !vote;
                     end
                     default: phase_q <= RX_HUNT;
                  endcase
               end
            end
         end
      end
   end

   // R3: a start bit voted high returns the receiver to hunting
   p_start_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && phase_q == RX_START && vote) |=> (phase_q == RX_HUNT));
   // R1: one completion pulse per frame
   p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R1: the data bit index stays inside the widest character
   p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == RX_BITS) |-> (idx_q <= LAST_WIDE));
endmodule

// File: rtl/awu_rx_regs.sv
module awu_rx_regs
   import awu_uart_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [1:0]        addr_i,
   input  logic [1:0]        wdata_i,
   input  logic              done_i,
   input  logic [DATA_W:0]   data_i,
   input  logic              noise_i,
   input  logic              stop_bad_i,
   input  logic              mark_i,
   output logic [DATA_W:0]   rdata_o,
   output logic              wide_o
);
   localparam int RD_W = DATA_W + 1;

   logic [DATA_W:0]        rdr_q;
   logic                   full_q, ovr_q, noise_q, ferr_q;
   logic                   wake_q, armed_q;
   logic [NUM_FLAGS-1:0]   snap_q, flags, clr;
   logic                   stat_rd, data_rd, ctrl_wr, blocked, accept, overrun;

   assign flags   = {ferr_q, noise_q, ovr_q, full_q};
   assign stat_rd = rd_i && (addr_i == REG_STAT);
   assign data_rd = rd_i && (addr_i == REG_DATA);
   assign ctrl_wr = wr_i && (addr_i == REG_CTRL);
   assign clr     = (data_rd && armed_q) ? snap_q : '0;
   assign blocked = full_q || ferr_q;
   assign accept  = done_i && !wake_q && !blocked;
   assign overrun = done_i && !wake_q && blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdr_q   <= '0;
         full_q  <= 1'b0;
         ovr_q   <= 1'b0;
         noise_q <= 1'b0;
         ferr_q  <= 1'b0;
         wake_q  <= 1'b0;
         wide_o  <= 1'b0;
         armed_q <= 1'b0;
         snap_q  <= '0;
      end else begin
         full_q  <= (full_q  & ~clr[FLG_FULL])  | accept;
         ovr_q   <= (ovr_q   & ~clr[FLG_OVR])   | overrun;
         noise_q <= (noise_q & ~clr[FLG_NOISE]) | (accept & noise_i);
         ferr_q  <= (ferr_q  & ~clr[FLG_FRAME]) | (accept & stop_bad_i);
         if (accept) rdr_q <= data_i;
         if (stat_rd) begin
            snap_q  <= flags;
            armed_q <= 1'b1;
         end else if (data_rd) begin
            armed_q <= 1'b0;
         end
         if (mark_i)       wake_q <= 1'b0;
         else if (ctrl_wr) wake_q <= wdata_i[0];
         if (ctrl_wr) wide_o <= wdata_i[1];
      end
   end

   always_comb begin
      case (addr_i)
         REG_STAT: rdata_o = RD_W'({wide_o, wake_q, flags});
         REG_DATA: rdata_o = rdr_q;
         REG_CTRL: rdata_o = RD_W'({wide_o, wake_q});
         default:  rdata_o = '0;
      endcase
   end

   p_noise_needs_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      noise_q |-> full_q);
   p_frame_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_q |-> full_q);
   p_rdr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q || ferr_q) |=> $stable(rdr_q));
   p_ovr_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && blocked && !wake_q && !data_rd) |=> $stable(ferr_q));
   p_clear_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !(data_rd && armed_q)) |=> ovr_q);
   p_wake_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_q && done_i && !data_rd) |=> ($stable(full_q) && $stable(rdr_q)));
   p_mark_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mark_i |=> !wake_q);
endmodule

// File: rtl/awu_uart_rx.sv
module awu_uart_rx
   import awu_uart_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick16_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [1:0]        addr_i,
   input  logic [1:0]        wdata_i,
   output logic [DATA_W:0]   rdata_o
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end
   if (STAT_W > DATA_W + 1) begin : g_bad_stat
      $error("status does not fit the read port");
   end

   logic            line;
   logic            done, noise, stop_bad, mark, wide;
   logic [DATA_W:0] frame;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line = rx_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], rx_i};
      end
      assign line = chain_q[SYNC_STAGES-1];
   end

   awu_rx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick16_i),
      .line_i     (line),
      .wide_i     (wide),
      .done_o     (done),
      .data_o     (frame),
      .noise_o    (noise),
      .stop_bad_o (stop_bad),
      .mark_o     (mark)
   );

   awu_rx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_i       (rd_i),
      .wr_i       (wr_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .done_i     (done),
      .data_i     (frame),
      .noise_i    (noise),
      .stop_bad_i (stop_bad),
      .mark_i     (mark),
      .rdata_o    (rdata_o),
      .wide_o     (wide)
   );
endmodule

// File: tb/awu_uart_rx_bench.sv
module awu_uart_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       tick = 1'b0;
   logic       rd = 1'b0;
   logic       wr = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [1:0] wdata = 2'd0;
   logic [8:0] rdata;
   int         checks = 0;
   int         failures = 0;
   logic       finished = 1'b0;

   always #2.5 clk = ~clk;

   awu_uart_rx u_awu_uart_rx (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16_i(tick),
      .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
   );

   initial forever begin
      @(negedge clk);
      tick = ~tick;
   end

   // {wide, data, stop_ok, glitch_bit(15 none), exp_status, exp_data}
   localparam int VW = 30;
   localparam logic [VW-1:0] VEC [8] = '{
      {1'b0, 9'h0A5, 1'b1, 4'hF, 6'h01, 9'h0A5},
      {1'b0, 9'h03C, 1'b1, 4'h3, 6'h05, 9'h03C},
      {1'b1, 9'h1C3, 1'b1, 4'hF, 6'h21, 9'h1C3},
      {1'b1, 9'h0FF, 1'b1, 4'h0, 6'h25, 9'h0FF},
      {1'b0, 9'h05A, 1'b0, 4'hF, 6'h09, 9'h05A},
      {1'b0, 9'h080, 1'b1, 4'hF, 6'h01, 9'h080},
      {1'b1, 9'h100, 1'b0, 4'hA, 6'h2D, 9'h100},
      {1'b0, 9'h001, 1'b1, 4'h8, 6'h05, 9'h001}
   };

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [8:0] v);
      @(negedge clk);
      rd = 1'b1; addr = a;
      #1 v = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic reg_write(input logic [1:0] v);
      @(negedge clk);
      wr = 1'b1; addr = 2'd2; wdata = v;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic slots(input int n, input logic v);
      rx = v;
      repeat (2 * n) @(negedge clk);
   endtask

   task automatic send(input logic wide, input logic [8:0] d, input logic stop_ok, input int glitch);
      int nb;
      nb = wide ? 9 : 8;
      for (int b = 0; b < nb + 2; b++) begin
         logic val;
         val = (b == 0) ? 1'b0 : (b <= nb) ? d[b-1] : stop_ok;
         for (int s = 0; s < 16; s++) begin
            rx = (b == glitch && s == 8) ? ~val : val;
            repeat (2) @(negedge clk);
         end
      end
      slots(10, 1'b1);
   endtask

   initial begin
      logic [8:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R10: reset state
      reg_read(2'd0, v); check("R10 status after reset", v, 9'h000);
      reg_read(2'd1, v); check("R10 data after reset", v, 9'h000);
      reg_read(2'd2, v); check("R10 control after reset", v, 9'h000);

      // Vector walk: R1 bit order and width, R2 noise, R4 framing
      for (int i = 0; i < 8; i++) begin
         logic [VW-1:0] e;
         e = VEC[i];
         reg_write({e[29], 1'b0});
         send(e[29], e[28:20], e[19], int'(e[18:15]));
         reg_read(2'd0, v); check("R1/R2/R4 vector status", v, {3'b000, e[14:9]});
         reg_read(2'd1, v); check("R1/R2/R4 vector data", v, e[8:0]);
         reg_read(2'd0, v); check("R7 cleared after vector", v, {3'b000, e[29], 5'b0});
      end
      reg_write(2'b00);

      // R3: short low pulse is rejected
      slots(4, 1'b0);
      slots(30, 1'b1);
      reg_read(2'd0, v); check("R3 false start ignored", v, 9'h000);

      // R5: overrun keeps old data
      send(1'b0, 9'h011, 1'b1, 15);
      send(1'b0, 9'h022, 1'b1, 15);
      reg_read(2'd0, v); check("R5 overrun status", v, 9'h003);
      reg_read(2'd1, v); check("R5 held data", v, 9'h011);
      reg_read(2'd0, v); check("R5 flags cleared", v, 9'h000);

      // R6: framing plus overrun reports overrun only
      send(1'b0, 9'h033, 1'b1, 15);
      send(1'b0, 9'h044, 1'b0, 15);
      reg_read(2'd0, v); check("R6 overrun only", v, 9'h003);
      reg_read(2'd1, v); check("R6 held data", v, 9'h033);

      // R5: pending framing error blocks the next character
      send(1'b0, 9'h055, 1'b0, 15);
      send(1'b0, 9'h066, 1'b1, 15);
      reg_read(2'd0, v); check("R5 framing blocks transfer", v, 9'h00B);
      reg_read(2'd1, v); check("R5 framing-held data", v, 9'h055);

      // R7: data read alone clears nothing
      send(1'b0, 9'h077, 1'b1, 15);
      reg_read(2'd1, v); check("R7 data read", v, 9'h077);
      reg_read(2'd0, v); check("R7 unarmed read kept full", v, 9'h001);
      reg_read(2'd1, v);
      reg_read(2'd0, v); check("R7 armed clear", v, 9'h000);
      // R7: flag raised after the status read survives
      reg_read(2'd0, v);
      send(1'b0, 9'h012, 1'b1, 15);
      reg_read(2'd1, v); check("R7 late data", v, 9'h012);
      reg_read(2'd0, v); check("R7 late flag survives", v, 9'h001);
      reg_read(2'd1, v);
      reg_read(2'd0, v); check("R7 late flag cleared", v, 9'h000);

      // R8/R9 narrow mode
      reg_write(2'b01);
      reg_read(2'd0, v); check("R8 wakeup bit shown", v, 9'h010);
      send(1'b0, 9'h021, 1'b1, 4);
      reg_read(2'd0, v); check("R8 skipped character no flags", v, 9'h010);
      reg_read(2'd1, v); check("R8 data unchanged", v, 9'h012);
      send(1'b0, 9'h09A, 1'b1, 15);
      reg_read(2'd0, v); check("R9 address char wakes", v, 9'h001);
      reg_read(2'd1, v); check("R9 address char data", v, 9'h09A);

      // R8/R9 wide mode
      reg_write(2'b11);
      reg_read(2'd0, v); check("R8 wide wakeup shown", v, 9'h030);
      send(1'b1, 9'h0FF, 1'b1, 15);
      reg_read(2'd0, v); check("R8 wide skipped", v, 9'h030);
      send(1'b1, 9'h155, 1'b1, 15);
      reg_read(2'd0, v); check("R9 wide wake status", v, 9'h021);
      reg_read(2'd1, v); check("R9 wide wake data", v, 9'h155);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule